// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Slot Squash

This block is the control logic for conditional branches in a short in-order pipeline. It owns the fetch address register and the fetch-to-decode pipeline register. It resolves a branch while the branch sits in decode, so a redirect costs at most one fetch slot. The condition is equality of two source operands. The destination is the address after the branch plus a sign-extended word offset, scaled by four. The block also decides whether the instruction fetched behind the branch proceeds or is replaced by an all-zero no-op.

An elaboration parameter picks one of three policies for that following slot. In flush mode, fetch runs ahead sequentially and the slot is squashed whenever the branch is taken. In slot mode, the slot always executes. In cancel mode, the branch carries a predicted-direction bit, and the slot is squashed only when the actual outcome differs from that bit.

A load-use stall input freezes the front end. The stall takes priority over any branch sitting in decode, and the branch is resolved once the stall drops.

Top module: `brx_ctrl`

## Requirements
- R1: While `rst` is high, on the clock edge the fetch address becomes `RESET_PC`, the decode word and decode address become zero, and `squash_o` becomes low.
- R2: With no stall and no branch in decode, each edge does three things: the fetch address advances by 4, the decode word takes `fetch_word_i`, and the decode address takes the old fetch address.
- R3: A branch in decode is taken exactly when `id_opa_i == id_opb_i`. On the next edge a taken branch loads the fetch address with decode address + 4 + (sign-extended 16-bit `id_offset_i` shifted left by 2). A branch that is not taken advances the fetch address by 4.
- R4: In flush mode (MODE = 0), a taken branch zeroes the word loaded into decode and raises `squash_o` for that one cycle. A branch that is not taken costs nothing and leaves `squash_o` low.
- R5: In slot mode (MODE = 1), the word behind a branch always enters decode unchanged, whatever the outcome, and `squash_o` stays low.
- R6: In cancel mode (MODE = 2), `id_pred_i` = 1 predicts taken. The slot word enters decode unchanged when the outcome matches the prediction. When the outcome differs, the slot word is zeroed and `squash_o` rises for one cycle. The redirect itself follows R3 in both cases.
- R7: While `stall_i` is high, all of the following hold: the fetch address, the decode word and the decode address keep their values; `squash_o` is low; and any branch in decode is left unresolved until the first edge without a stall.
- R8: Whenever `squash_o` is high, the decode word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Load-use stall; holds the front end |
| fetch_word_i | input | IW | Instruction word read at `fetch_pc_o` |
| id_branch_i | input | 1 | Decode word is a conditional branch |
| id_pred_i | input | 1 | Predicted direction of the branch (1 = taken) |
| id_offset_i | input | OFFW | Word offset field of the branch |
| id_opa_i | input | DW | First compared operand |
| id_opb_i | input | DW | Second compared operand |
| fetch_pc_o | output | AW | Current fetch address |
| ifid_word_o | output | IW | Instruction word held for decode |
| ifid_pc_o | output | AW | Address of the word held for decode |
| squash_o | output | 1 | Decode word is a squashed slot |

## Verification
The assertions assume the branch flag, prediction bit and operands come from a decoder that looks at `ifid_word_o`. They also assume no branch ever follows another branch directly in fetch order, so a delay slot never holds a branch. The bench keeps to this in two ways. Its instruction image places branches only at word indices that are multiples of four. Its decoder derives every decode input from the current decode word, so an all-zero squashed word never reads as a branch. Operand equality is varied over time by a toggling bit applied to one operand, so loops in the image keep changing direction. The stall is driven at random, including cycles with a branch waiting in decode.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    BR_FLUSH  = 2'd0,
    BR_SLOT   = 2'd1,
    BR_CANCEL = 2'd2
  } br_mode_e;
endpackage

// File: rtl/brx_target_calc.sv
module brx_target_calc #(
  parameter int AW   = 32,
  parameter int OFFW = 16
) (
  input  logic [AW-1:0]   dec_pc,
  input  logic [OFFW-1:0] offset,
  output logic [AW-1:0]   tgt_pc
);
  localparam int EXTW = AW - OFFW - 2;
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [AW-1:0] disp;
  logic [AW-1:0] after_pc;

  // sign-extend the word offset and scale to bytes
  assign disp     = {{EXTW{offset[OFFW-1]}}, offset, 2'b00};
  assign after_pc = dec_pc + WORD_STEP;
  assign tgt_pc   = after_pc + disp;
endmodule

// File: rtl/brx_decide.sv
module brx_decide
  import brx_pkg::*;
#(
  parameter int       DW   = 32,
  parameter br_mode_e MODE = BR_FLUSH
) (
  input  logic          br_live,
  input  logic          pred,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          redirect,
  output logic          kill
);
  logic cond;
  logic pred_unused;

  assign pred_unused = pred;
  assign cond        = (opa == opb);
  assign redirect    = br_live & cond;

  generate
    if (MODE == BR_FLUSH) begin : g_flush
      // sequential fetch was wrong whenever the branch goes
      assign kill = br_live & cond;
    end else if (MODE == BR_SLOT) begin : g_slot
      assign kill = 1'b0;
    end else begin : g_cancel
      // slot survives only when the encoded guess was right
      assign kill = br_live & (cond ^ pred);
    end
  endgenerate
endmodule

// File: rtl/brx_front_regs.sv
module brx_front_regs #(
  parameter int            AW       = 32,
  parameter int            IW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          redirect,
  input  logic          kill,
  input  logic [AW-1:0] tgt_pc,
  input  logic [IW-1:0] fetch_word,
  output logic [AW-1:0] pc_q,
  output logic [IW-1:0] word_q,
  output logic [AW-1:0] dpc_q,
  output logic          kill_q
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      word_q <= '0;
      dpc_q  <= '0;
      kill_q <= 1'b0;
    end else if (hold) begin
      kill_q <= 1'b0;
    end else begin
      pc_q   <= redirect ? tgt_pc : pc_q + WORD_STEP;
      word_q <= kill ? '0 : fetch_word;
      dpc_q  <= pc_q;
      kill_q <= kill;
    end
  end
endmodule

// File: rtl/brx_ctrl.sv
module brx_ctrl
  import brx_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            IW       = 32,
  parameter int            DW       = 32,
  parameter int            OFFW     = 16,
  parameter br_mode_e      MODE     = BR_FLUSH,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic [IW-1:0]   fetch_word_i,
  input  logic            id_branch_i,
  input  logic            id_pred_i,
  input  logic [OFFW-1:0] id_offset_i,
  input  logic [DW-1:0]   id_opa_i,
  input  logic [DW-1:0]   id_opb_i,
  output logic [AW-1:0]   fetch_pc_o,
  output logic [IW-1:0]   ifid_word_o,
  output logic [AW-1:0]   ifid_pc_o,
  output logic            squash_o
);
  logic          br_live;
  logic          redirect;
  logic          kill;
  logic [AW-1:0] tgt_pc;

  // a stall wins: the branch waits in decode
  assign br_live = id_branch_i & ~stall_i;

  brx_target_calc #(.AW(AW), .OFFW(OFFW)) i_target (
    .dec_pc (ifid_pc_o),
    .offset (id_offset_i),
    .tgt_pc (tgt_pc)
  );

  brx_decide #(.DW(DW), .MODE(MODE)) i_decide (
    .br_live  (br_live),
    .pred     (id_pred_i),
    .opa      (id_opa_i),
    .opb      (id_opb_i),
    .redirect (redirect),
    .kill     (kill)
  );

  brx_front_regs #(.AW(AW), .IW(IW), .RESET_PC(RESET_PC)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .hold       (stall_i),
    .redirect   (redirect),
    .kill       (kill),
    .tgt_pc     (tgt_pc),
    .fetch_word (fetch_word_i),
    .pc_q       (fetch_pc_o),
    .word_q     (ifid_word_o),
    .dpc_q      (ifid_pc_o),
    .kill_q     (squash_o)
  );
endmodule

// File: rtl/brx_ctrl_chk.sv
module brx_ctrl_chk
  import brx_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            IW       = 32,
  parameter int            DW       = 32,
  parameter br_mode_e      MODE     = BR_FLUSH,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          stall_i,
  input logic          id_branch_i,
  input logic          id_pred_i,
  input logic [DW-1:0] id_opa_i,
  input logic [DW-1:0] id_opb_i,
  input logic [AW-1:0] fetch_pc_o,
  input logic [IW-1:0] ifid_word_o,
  input logic [AW-1:0] ifid_pc_o,
  input logic          squash_o
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_pc_o == RESET_PC && ifid_word_o == '0 && !squash_o));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!stall_i && !id_branch_i)) |->
      (fetch_pc_o == $past(fetch_pc_o) + WORD_STEP && ifid_pc_o == $past(fetch_pc_o)));

  // R3
  not_taken_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!stall_i && id_branch_i && id_opa_i != id_opb_i)) |->
      fetch_pc_o == $past(fetch_pc_o) + WORD_STEP);

  // R4
  flush_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == BR_FLUSH && !$past(rst) && $past(!stall_i && id_branch_i)) |->
      (squash_o == $past(id_opa_i == id_opb_i)));

  // R5
  slot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == BR_SLOT && !$past(rst) && $past(!stall_i && id_branch_i)) |->
      (!squash_o && ifid_pc_o == $past(fetch_pc_o)));

  // R6
  cancel_guess_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == BR_CANCEL && !$past(rst) && $past(!stall_i && id_branch_i)) |->
      (squash_o == $past((id_opa_i == id_opb_i) != id_pred_i)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stall_i)) |->
      ($stable(fetch_pc_o) && $stable(ifid_word_o) && $stable(ifid_pc_o) && !squash_o));

  // R8
  squash_zero_chk: assert property (@(posedge clk) disable iff (rst)
    squash_o |-> ifid_word_o == '0);
endmodule

bind brx_ctrl brx_ctrl_chk #(
  .AW(AW), .IW(IW), .DW(DW), .MODE(MODE), .RESET_PC(RESET_PC)
) i_brx_chk (
  .clk         (clk),
  .rst         (rst),
  .stall_i     (stall_i),
  .id_branch_i (id_branch_i),
  .id_pred_i   (id_pred_i),
  .id_opa_i    (id_opa_i),
  .id_opb_i    (id_opb_i),
  .fetch_pc_o  (fetch_pc_o),
  .ifid_word_o (ifid_word_o),
  .ifid_pc_o   (ifid_pc_o),
  .squash_o    (squash_o)
);

// File: tb/test_brx_ctrl.sv
`timescale 1ns/1ps
module test_brx_ctrl;
  import brx_pkg::*;

  localparam logic [31:0] RPC    = 32'h0000_0100;
  localparam int          CYCLES = 4000;

  logic clk = 1'b0;
  logic rst;
  logic stall;
  logic flip;
  logic [15:0] lfsr;

  always #4 clk = ~clk;

  logic [31:0] f_pc [3];
  logic [31:0] iw   [3];
  logic [31:0] ipc  [3];
  logic        sq   [3];
  logic [31:0] fw   [3];
  logic        br   [3];
  logic        pr   [3];
  logic [15:0] off  [3];
  logic [31:0] oa   [3];
  logic [31:0] ob   [3];

  // Instruction image: branches only at word indices that are multiples of four.
  // Branch word: bit31=1, bit30=prediction, [25:21]/[20:16] operand fields, [15:0] offset.
  function automatic logic [31:0] imem(input logic [31:0] a);
    logic [29:0] k;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] o;
    k = a[31:2];
    if (k[1:0] != 2'd0) return {8'h11, k[23:0]};
    rs = {2'b00, k[4:2]};
    rt = k[6] ? rs : (rs ^ 5'd2);
    case (k[9:8])
      2'd0:    o = 16'(k[5:2]) + 16'd3;
      2'd1:    o = 16'd0 - (16'(k[5:2]) + 16'd2);
      2'd2:    o = 16'h7FF0 | 16'(k[5:2]);
      default: o = 16'h8000 | 16'(k[5:2]);
    endcase
    return {1'b1, k[5], 4'b0000, rs, rt, o};
  endfunction

  for (genvar m = 0; m < 3; m++) begin : g_dec
    assign fw[m]  = imem(f_pc[m]);
    assign br[m]  = iw[m][31];
    assign pr[m]  = iw[m][30];
    assign off[m] = iw[m][15:0];
    assign oa[m]  = {27'b0, iw[m][25:21]};
    assign ob[m]  = {27'b0, iw[m][20:16] ^ {4'b0000, flip}};
  end

  brx_ctrl #(.MODE(BR_FLUSH), .RESET_PC(RPC)) i_brx_ctrl (
    .clk(clk), .rst(rst), .stall_i(stall), .fetch_word_i(fw[0]),
    .id_branch_i(br[0]), .id_pred_i(pr[0]), .id_offset_i(off[0]),
    .id_opa_i(oa[0]), .id_opb_i(ob[0]), .fetch_pc_o(f_pc[0]),
    .ifid_word_o(iw[0]), .ifid_pc_o(ipc[0]), .squash_o(sq[0]));

  brx_ctrl #(.MODE(BR_SLOT), .RESET_PC(RPC)) i_brx_ctrl_slot (
    .clk(clk), .rst(rst), .stall_i(stall), .fetch_word_i(fw[1]),
    .id_branch_i(br[1]), .id_pred_i(pr[1]), .id_offset_i(off[1]),
    .id_opa_i(oa[1]), .id_opb_i(ob[1]), .fetch_pc_o(f_pc[1]),
    .ifid_word_o(iw[1]), .ifid_pc_o(ipc[1]), .squash_o(sq[1]));

  brx_ctrl #(.MODE(BR_CANCEL), .RESET_PC(RPC)) i_brx_ctrl_cancel (
    .clk(clk), .rst(rst), .stall_i(stall), .fetch_word_i(fw[2]),
    .id_branch_i(br[2]), .id_pred_i(pr[2]), .id_offset_i(off[2]),
    .id_opa_i(oa[2]), .id_opb_i(ob[2]), .fetch_pc_o(f_pc[2]),
    .ifid_word_o(iw[2]), .ifid_pc_o(ipc[2]), .squash_o(sq[2]));

  int n_cmp = 0;
  int n_bad = 0;
  int cycles_run = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected state per mode
  logic [31:0] e_pc  [3];
  logic [31:0] e_w   [3];
  logic [31:0] e_ipc [3];
  logic        e_sq  [3];
  string       tag   [3];

  int c_flush_taken = 0, c_flush_nt = 0, c_slot_taken = 0, c_slot_nt = 0;
  int c_cancel_miss = 0, c_cancel_hit = 0, c_stall_br = 0, c_neg_taken = 0;

  task automatic model_step();
    for (int m = 0; m < 3; m++) begin
      logic        isb, pd, taken, kill;
      logic [4:0]  rs, rt;
      logic [15:0] o;
      logic [31:0] tgt, nw;
      isb   = e_w[m][31];
      pd    = e_w[m][30];
      rs    = e_w[m][25:21];
      rt    = e_w[m][20:16] ^ {4'b0000, flip};
      o     = e_w[m][15:0];
      taken = isb && (rs == rt);
      if (stall) begin
        e_sq[m] = 1'b0;
        tag[m]  = "R7";
        if (isb) c_stall_br++;
      end else begin
        tgt  = e_ipc[m] + 32'd4 + {{14{o[15]}}, o, 2'b00};
        kill = (m == 0 && taken) || (m == 2 && isb && (taken != pd));
        if (!isb) tag[m] = "R2";
        else if (m == 0) tag[m] = "R4";
        else if (m == 1) tag[m] = "R5";
        else tag[m] = "R6";
        if (isb && m == 0) begin if (taken) c_flush_taken++; else c_flush_nt++; end
        if (isb && m == 1) begin if (taken) c_slot_taken++; else c_slot_nt++; end
        if (isb && m == 2) begin if (taken != pd) c_cancel_miss++; else c_cancel_hit++; end
        if (taken && o[15]) c_neg_taken++;
        nw       = kill ? 32'd0 : imem(e_pc[m]);
        e_ipc[m] = e_pc[m];
        e_pc[m]  = taken ? tgt : e_pc[m] + 32'd4;
        e_w[m]   = nw;
        e_sq[m]  = kill;
      end
    end
  endtask

  task automatic compare();
    for (int m = 0; m < 3; m++) begin
      chk(f_pc[m] == e_pc[m], tag[m] == "R2" ? "R2" : {tag[m], "/R3"}, "fetch pc", f_pc[m], e_pc[m]);
      chk(iw[m] == e_w[m], e_sq[m] ? "R8" : tag[m], "decode word", iw[m], e_w[m]);
      chk(ipc[m] == e_ipc[m], tag[m], "decode pc", ipc[m], e_ipc[m]);
      chk(sq[m] == e_sq[m], tag[m], "squash", {31'b0, sq[m]}, {31'b0, e_sq[m]});
    end
  endtask

  initial begin : watchdog
    repeat (CYCLES + 200) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst   = 1'b1;
    stall = 1'b0;
    flip  = 1'b0;
    lfsr  = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    for (int m = 0; m < 3; m++) begin
      chk(f_pc[m] == RPC, "R1", "reset fetch pc", f_pc[m], RPC);
      chk(iw[m] == 32'd0, "R1", "reset decode word", iw[m], 32'd0);
      chk(sq[m] == 1'b0, "R1", "reset squash", {31'b0, sq[m]}, 32'd0);
      e_pc[m] = RPC; e_w[m] = 32'd0; e_ipc[m] = 32'd0; e_sq[m] = 1'b0;
    end
    rst = 1'b0;
    for (int c = 0; c < CYCLES; c++) begin
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall = (lfsr[3:0] == 4'd0) || (lfsr[3:0] == 4'd9);
      flip  = (lfsr[7:5] == 3'd0);
      model_step();
      @(negedge clk);
      cycles_run++;
      compare();
    end
    // coverage of each requirement's corner
    chk(c_flush_taken > 0, "R4", "taken branches in flush mode", c_flush_taken, 1);
    chk(c_flush_nt > 0, "R4", "not-taken branches in flush mode", c_flush_nt, 1);
    chk(c_slot_taken > 0 && c_slot_nt > 0, "R5", "both outcomes in slot mode", c_slot_taken, 1);
    chk(c_cancel_miss > 0, "R6", "mispredicted cancel branches", c_cancel_miss, 1);
    chk(c_cancel_hit > 0, "R6", "correctly predicted cancel branches", c_cancel_hit, 1);
    chk(c_stall_br > 0, "R7", "stalls with a branch waiting", c_stall_br, 1);
    chk(c_neg_taken > 0, "R3", "taken negative offsets", c_neg_taken, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule